// File: doc/BRIEF.md
# DDR3 Write-Leveling Sequencer

This block is the controller-side engine that levels the write strobe of one DRAM rank. After a `start` pulse it loads mode register 1 with the write-leveling bit set. It then waits out the mode-register settle time and raises on-die termination. It waits again before it drives the strobe to its idle-low level, and then fires a series of single strobe pulses. Between the entry load and the exit load it issues only NOP commands.

After each pulse the sequencer waits for the DRAM's asynchronous feedback to settle. It then captures the OR of all DQ lanes, so a rank that answers on one prime lane works the same way as one that answers on every lane. The strobe delay code sweeps upward from zero, one step per pulse. The first pair of consecutive samples that reads 0 and then 1 locks the code. If the code reaches its top value with no such pair, the sequencer flags an error instead. In both cases it drops termination and the strobe, loads mode register 1 again with leveling cleared, and pulses `done`.

All waits are parameters counted in controller clock cycles. The delay line, the PHY and the traffic to other ranks are outside this block.

Top module: `wrlvl_seq`

## Requirements
- R1: The first MRS of a run drives `mrAddr` equal to `mr1Base` with bit 7 set to 1 and bit 12 cleared to 0. All other bits are copied unchanged.
- R2: Each run issues exactly two cycles with `cmdMrs` high, the entry and the exit. Every other cycle of the run is a NOP, with `cmdMrs` low.
- R3: `odt` rises no earlier than T_MOD cycles after the entry MRS cycle.
- R4: `dqsOe` rises no earlier than T_DQSEN cycles after `odt` rises. `dqsPulse` is high only while both `odt` and `dqsOe` are high.
- R5: The first strobe pulse starts at least max(T_MRD, T_DQSL) cycles after `dqsOe` rises. Every pulse is high for exactly T_DQSH cycles. The low time between pulses is at least T_DQSL cycles.
- R6: The captured feedback is the OR of all `dqFb` lanes, taken in the cycle that lies T_DQSH+T_WLO cycles after the first high cycle of the pulse. Values on `dqFb` before that cycle have no effect.
- R7: `delayCode` is 0 at the first pulse of a run and goes up by one after each sample that does not complete a 0-then-1 pair. When two consecutive samples read 0 and then 1, `lockFlag` is set and the code stays at the value used for the second of those pulses.
- R8: If the sample at the top code (all ones) does not complete a 0-then-1 pair, `errFlag` is set and `delayCode` stays at the top value without wrapping. `lockFlag` and `errFlag` are never both high.
- R9: `odt` and `dqsOe` are low for T_GAP cycles before the exit MRS. The exit MRS drives `mrAddr` equal to `mr1Base` with bits 7 and 12 cleared.
- R10: `done` is high for exactly one cycle, the cycle after the exit MRS. A `start` pulse while a run is in progress is ignored.
- R11: After reset every output is 0. After a run, `lockFlag`, `errFlag` and `delayCode` hold their values while idle, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a leveling run (honoured only when idle) |
| mr1Base | input | ADDR_W | MR1 value for the other fields of the register |
| dqFb | input | DQ_W | Leveling feedback from the DQ lanes |
| cmdMrs | output | 1 | 1 = mode-register load, 0 = NOP |
| mrAddr | output | ADDR_W | Address bus value during the mode-register load, 0 otherwise |
| odt | output | 1 | On-die termination request |
| dqsOe | output | 1 | Strobe driven (low unless pulsing) |
| dqsPulse | output | 1 | Strobe high phase |
| delayCode | output | CODE_W | Strobe delay setting |
| lockFlag | output | 1 | A 0-to-1 transition was found |
| errFlag | output | 1 | Sweep ended without a transition |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Embedded properties watch the ordering and spacing of the protocol on every cycle. They check the T_MOD gap from MRS to termination and the T_DQSEN gap from termination to strobe, that pulses only occur inside that window, the exact pulse width, that termination is off at any MRS, that the code never wraps, that `lock` and `err` are exclusive, and that `done` lasts one cycle. Only the bench scenarios can show the function of the sweep itself. A DRAM model answers on a prime lane or on all lanes, and before the sample point it drives inverted values. That lets the scenarios show that the code locks at the right step, that a rank answering 1 from the start or never answering ends in error at the saturated top code, that the address fields and the low phase are correct, and that a mid-run `start` has no effect.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;

  // which wait the datapath counter is loaded with
  typedef enum logic [2:0] {
    W_MOD,
    W_DQSEN,
    W_MRD,
    W_HIGH,
    W_WLO,
    W_GAP
  } waitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     cntLoad;
    waitSel_e waitSel;
    logic     codeClr;
    logic     codeInc;
    logic     fbTake;
    logic     histClr;
  } dpStrb_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ENTER,
    S_MOD,
    S_ODT,
    S_PRE,
    S_HIGH,
    S_WLO,
    S_SAMP,
    S_GAP,
    S_ODTOFF,
    S_EXIT,
    S_DONE
  } seqState_e;

endpackage

// File: rtl/wrlvl_dp.sv
module wrlvl_dp
  import wrlvl_pkg::*;
#(
  parameter int CODE_W  = 5,
  parameter int CNT_W   = 8,
  parameter int DQ_W    = 8,
  parameter int T_MOD   = 12,
  parameter int T_DQSEN = 25,
  parameter int T_MRD   = 40,
  parameter int T_DQSL  = 3,
  parameter int T_DQSH  = 3,
  parameter int T_WLO   = 8,
  parameter int T_GAP   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [DQ_W-1:0]   dqFb,
  output logic              cntDone,
  output logic              edgeHit,
  output logic              codeMax,
  output logic [CODE_W-1:0] delayCode
);

  localparam int MRD_WAIT = (T_MRD > T_DQSL) ? T_MRD : T_DQSL;
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             fbNow;
  logic             prevFb;
  logic             prevValid;

  // wait selector: a state entered with N-1 lasts N cycles
  always_comb begin
    case (strb.waitSel)
      W_MOD:   loadVal = CNT_W'(T_MOD - 1);
      W_DQSEN: loadVal = CNT_W'(T_DQSEN - 1);
      W_MRD:   loadVal = CNT_W'(MRD_WAIT - 1);
      W_HIGH:  loadVal = CNT_W'(T_DQSH - 1);
      W_WLO:   loadVal = CNT_W'(T_WLO - 1);
      W_GAP:   loadVal = CNT_W'(T_GAP - 1);
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (strb.cntLoad) cnt <= loadVal;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign cntDone = (cnt == '0);

  // feedback history: OR of lanes covers prime-lane and all-lane styles
  assign fbNow = |dqFb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFb    <= 1'b0;
      prevValid <= 1'b0;
    end else if (strb.histClr) begin
      prevFb    <= 1'b0;
      prevValid <= 1'b0;
    end else if (strb.fbTake) begin
      prevFb    <= fbNow;
      prevValid <= 1'b1;
    end
  end

  assign edgeHit = prevValid && !prevFb && fbNow;

  // saturating delay code
  always_ff @(posedge clk) begin
    if (!rstN)                                   delayCode <= '0;
    else if (strb.codeClr)                       delayCode <= '0;
    else if (strb.codeInc && delayCode != CODE_TOP) delayCode <= delayCode + 1'b1;
  end

  assign codeMax = (delayCode == CODE_TOP);

  // R8
  code_nowrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (delayCode == CODE_TOP && !strb.codeClr) |=> delayCode == CODE_TOP);

endmodule

// File: rtl/wrlvl_ctl.sv
module wrlvl_ctl
  import wrlvl_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int CNT_W    = 8,
  parameter int WL_BIT   = 7,
  parameter int QOFF_BIT = 12,
  parameter int T_MOD    = 12,
  parameter int T_DQSEN  = 25,
  parameter int T_DQSH   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cntDone,
  input  logic              edgeHit,
  input  logic              codeMax,
  input  logic [ADDR_W-1:0] mr1Base,
  output dpStrb_t           strb,
  output logic              cmdMrs,
  output logic [ADDR_W-1:0] mrAddr,
  output logic              odt,
  output logic              dqsOe,
  output logic              dqsPulse,
  output logic              lockFlag,
  output logic              errFlag,
  output logic              done
);

  seqState_e state, nextState;
  logic lockSet, errSet, flagClr;
  logic [ADDR_W-1:0] entryAddr, exitAddr;

  always_comb begin
    entryAddr           = mr1Base;
    entryAddr[WL_BIT]   = 1'b1;
    entryAddr[QOFF_BIT] = 1'b0;
    exitAddr            = mr1Base;
    exitAddr[WL_BIT]    = 1'b0;
    exitAddr[QOFF_BIT]  = 1'b0;
  end

  // next state and strobes
  always_comb begin
    nextState    = state;
    strb         = '0;
    strb.waitSel = W_MOD;
    lockSet      = 1'b0;
    errSet       = 1'b0;
    flagClr      = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        nextState    = S_ENTER;
        strb.codeClr = 1'b1;
        strb.histClr = 1'b1;
        flagClr      = 1'b1;
      end
      S_ENTER: begin
        nextState    = S_MOD;
        strb.cntLoad = 1'b1;
        strb.waitSel = W_MOD;
      end
      S_MOD: if (cntDone) begin
        nextState    = S_ODT;
        strb.cntLoad = 1'b1;
        strb.waitSel = W_DQSEN;
      end
      S_ODT: if (cntDone) begin
        nextState    = S_PRE;
        strb.cntLoad = 1'b1;
        strb.waitSel = W_MRD;
      end
      S_PRE, S_GAP: if (cntDone) begin
        nextState    = S_HIGH;
        strb.cntLoad = 1'b1;
        strb.waitSel = W_HIGH;
      end
      S_HIGH: if (cntDone) begin
        nextState    = S_WLO;
        strb.cntLoad = 1'b1;
        strb.waitSel = W_WLO;
      end
      S_WLO: if (cntDone) nextState = S_SAMP;
      S_SAMP: begin
        strb.fbTake  = 1'b1;
        strb.cntLoad = 1'b1;
        strb.waitSel = W_GAP;
        if (edgeHit) begin
          lockSet   = 1'b1;
          nextState = S_ODTOFF;
        end else if (codeMax) begin
          errSet    = 1'b1;
          nextState = S_ODTOFF;
        end else begin
          strb.codeInc = 1'b1;
          nextState    = S_GAP;
        end
      end
      S_ODTOFF: if (cntDone) nextState = S_EXIT;
      S_EXIT:   nextState = S_DONE;
      S_DONE:   nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flagClr) begin
      lockFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (lockSet) lockFlag <= 1'b1;
      if (errSet)  errFlag  <= 1'b1;
    end
  end

  // Moore outputs
  always_comb begin
    cmdMrs   = (state == S_ENTER) || (state == S_EXIT);
    mrAddr   = (state == S_ENTER) ? entryAddr :
               (state == S_EXIT)  ? exitAddr  : '0;
    odt      = (state == S_ODT) || (state == S_PRE) || (state == S_HIGH) ||
               (state == S_WLO) || (state == S_SAMP) || (state == S_GAP);
    dqsOe    = (state == S_PRE) || (state == S_HIGH) || (state == S_WLO) ||
               (state == S_SAMP) || (state == S_GAP);
    dqsPulse = (state == S_HIGH);
    done     = (state == S_DONE);
  end

  // spacing monitors used by the properties below
  logic [CNT_W-1:0] sinceMrs, sinceOdt, highRun;
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceMrs <= '0;
      sinceOdt <= '0;
      highRun  <= '0;
    end else begin
      if (cmdMrs)              sinceMrs <= '0;
      else if (sinceMrs != SAT) sinceMrs <= sinceMrs + 1'b1;
      if (!odt)                sinceOdt <= '0;
      else if (sinceOdt != SAT) sinceOdt <= sinceOdt + 1'b1;
      if (!dqsPulse)           highRun  <= '0;
      else if (highRun != SAT)  highRun  <= highRun + 1'b1;
    end
  end

  // R3
  odt_after_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(odt) |-> sinceMrs >= CNT_W'(T_MOD));

  // R4
  dqs_after_odt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqsOe) |-> sinceOdt >= CNT_W'(T_DQSEN));

  // R4
  pulse_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqsPulse |-> (odt && dqsOe));

  // R5
  pulse_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqsPulse) |-> highRun == CNT_W'(T_DQSH));

  // R9
  odt_off_at_mrs_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdMrs |-> (!odt && !dqsOe));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lockFlag && errFlag));

endmodule

// File: rtl/wrlvl_seq.sv
module wrlvl_seq
  import wrlvl_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int CNT_W    = 8,
  parameter int DQ_W     = 8,
  parameter int ADDR_W   = 14,
  parameter int WL_BIT   = 7,
  parameter int QOFF_BIT = 12,
  parameter int T_MOD    = 12,
  parameter int T_DQSEN  = 25,
  parameter int T_MRD    = 40,
  parameter int T_DQSL   = 3,
  parameter int T_DQSH   = 3,
  parameter int T_WLO    = 8,
  parameter int T_GAP    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] mr1Base,
  input  logic [DQ_W-1:0]   dqFb,
  output logic              cmdMrs,
  output logic [ADDR_W-1:0] mrAddr,
  output logic              odt,
  output logic              dqsOe,
  output logic              dqsPulse,
  output logic [CODE_W-1:0] delayCode,
  output logic              lockFlag,
  output logic              errFlag,
  output logic              done
);

  dpStrb_t strb;
  logic    cntDone, edgeHit, codeMax;

  wrlvl_ctl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WL_BIT(WL_BIT), .QOFF_BIT(QOFF_BIT),
    .T_MOD(T_MOD), .T_DQSEN(T_DQSEN), .T_DQSH(T_DQSH)
  ) ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .cntDone(cntDone), .edgeHit(edgeHit), .codeMax(codeMax),
    .mr1Base(mr1Base), .strb(strb),
    .cmdMrs(cmdMrs), .mrAddr(mrAddr), .odt(odt), .dqsOe(dqsOe),
    .dqsPulse(dqsPulse), .lockFlag(lockFlag), .errFlag(errFlag), .done(done)
  );

  wrlvl_dp #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .DQ_W(DQ_W),
    .T_MOD(T_MOD), .T_DQSEN(T_DQSEN), .T_MRD(T_MRD), .T_DQSL(T_DQSL),
    .T_DQSH(T_DQSH), .T_WLO(T_WLO), .T_GAP(T_GAP)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dqFb(dqFb),
    .cntDone(cntDone), .edgeHit(edgeHit), .codeMax(codeMax),
    .delayCode(delayCode)
  );

endmodule

// File: tb/wrlvl_seq_test.sv
module wrlvl_seq_test;

  localparam int CODE_W  = 4;
  localparam int DQ_W    = 8;
  localparam int ADDR_W  = 14;
  localparam int T_MOD   = 6;
  localparam int T_DQSEN = 5;
  localparam int T_MRD   = 8;
  localparam int T_DQSL  = 3;
  localparam int T_DQSH  = 2;
  localparam int T_WLO   = 4;
  localparam int T_GAP   = 3;
  localparam int MRDW    = (T_MRD > T_DQSL) ? T_MRD : T_DQSL;
  localparam int TOP     = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] mr1Base = '0;
  logic [DQ_W-1:0]   dqFb = '0;
  logic cmdMrs, odt, dqsOe, dqsPulse, lockFlag, errFlag, done;
  logic [ADDR_W-1:0] mrAddr;
  logic [CODE_W-1:0] delayCode;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  wrlvl_seq #(
    .CODE_W(CODE_W), .CNT_W(8), .DQ_W(DQ_W), .ADDR_W(ADDR_W),
    .WL_BIT(7), .QOFF_BIT(12),
    .T_MOD(T_MOD), .T_DQSEN(T_DQSEN), .T_MRD(T_MRD), .T_DQSL(T_DQSL),
    .T_DQSH(T_DQSH), .T_WLO(T_WLO), .T_GAP(T_GAP)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .mr1Base(mr1Base), .dqFb(dqFb),
    .cmdMrs(cmdMrs), .mrAddr(mrAddr), .odt(odt), .dqsOe(dqsOe),
    .dqsPulse(dqsPulse), .delayCode(delayCode), .lockFlag(lockFlag),
    .errFlag(errFlag), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] expEntry(input logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] r = b;
    r[7] = 1'b1; r[12] = 1'b0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] expExit(input logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] r = b;
    r[7] = 1'b0; r[12] = 1'b0;
    return r;
  endfunction

  // trip: DRAM answers 1 once code >= trip; trip 0 = always 1, trip > TOP = never
  function automatic bit expLock(input int trip);
    return (trip >= 1 && trip <= TOP);
  endfunction

  function automatic int expCode(input int trip);
    return expLock(trip) ? trip : TOP;
  endfunction

  task automatic runOne(input int trip, input bit prime, input int lane, input bit poke);
    int cyc = 0, mrsN = 0, doneN = 0, doneC = -1, pulses = 0;
    int riseC = -1, fallC = -1, oeC = -1, odtC = -1, mrsC = -1;
    logic [ADDR_W-1:0] entA = '0, exA = '0;
    bit odtAtExit = 1'b0, badNop = 1'b0, badHigh = 1'b0, badLow = 1'b0, badFirst = 1'b0;
    bit fbTrue = 1'b0, prevP = 1'b0, prevO = 1'b0, prevOe = 1'b0;
    bit lockAtDone = 1'b0, errAtDone = 1'b0;
    int codeAtDone = 0;
    logic [DQ_W-1:0] good;
    mr1Base = ADDR_W'($urandom);
    @(negedge clk);
    start = 1'b1;
    while (cyc < 3000 && !(doneC >= 0 && cyc >= doneC + 2)) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 30);
      if (cmdMrs) begin
        if (mrsN == 0) begin mrsC = cyc; entA = mrAddr; end
        else begin exA = mrAddr; odtAtExit = odt | dqsOe; end
        if (mrsN >= 2) badNop = 1'b1;
        mrsN++;
      end
      if (odt && !prevO && odtC < 0) odtC = cyc;
      if (dqsOe && !prevOe && oeC < 0) oeC = cyc;
      if (dqsPulse && !prevP) begin
        pulses++;
        if (fallC < 0) begin
          if (cyc - oeC < MRDW) badFirst = 1'b1;
        end else if (cyc - fallC < T_DQSL) badLow = 1'b1;
        riseC  = cyc;
        fbTrue = (int'(delayCode) >= trip);
      end
      if (!dqsPulse && prevP) begin
        fallC = cyc;
        if (cyc - riseC != T_DQSH) badHigh = 1'b1;
      end
      if (done) begin
        doneN++;
        if (doneC < 0) begin
          doneC = cyc;
          lockAtDone = lockFlag; errAtDone = errFlag; codeAtDone = int'(delayCode);
          // R10: done comes the cycle after the exit MRS
          chk(mrsN == 2, "R10 done after exit", mrsN, 2);
        end
      end
      prevP = dqsPulse; prevO = odt; prevOe = dqsOe;
      // DRAM model: value valid only from the sample point on, inverted before (R6)
      good = fbTrue ? (prime ? DQ_W'(1) << lane : '1) : '0;
      if (riseC >= 0 && cyc - riseC >= T_DQSH + T_WLO) dqFb = good;
      else dqFb = ~good;
    end
    start = 1'b0;
    chk(doneC >= 0, "R10 run finished", doneC, 1);
    chk(entA == expEntry(mr1Base), "R1 entry address", int'(entA), int'(expEntry(mr1Base)));
    chk(mrsN == 2 && !badNop, "R2 only NOP between MRS", mrsN, 2);
    chk(odtC - mrsC >= T_MOD, "R3 odt after tMOD", odtC - mrsC, T_MOD);
    chk(oeC - odtC >= T_DQSEN, "R4 dqs after odt", oeC - odtC, T_DQSEN);
    chk(!badFirst, "R5 first pulse spacing", int'(badFirst), 0);
    chk(!badHigh, "R5 pulse high width", int'(badHigh), 0);
    chk(!badLow, "R5 pulse low width", int'(badLow), 0);
    chk(pulses == expCode(trip) + 1, "R6 R7 pulse count", pulses, expCode(trip) + 1);
    chk(codeAtDone == expCode(trip), "R7 R8 final code", codeAtDone, expCode(trip));
    chk(lockAtDone == expLock(trip), "R7 lock flag", int'(lockAtDone), int'(expLock(trip)));
    chk(errAtDone == !expLock(trip), "R8 err flag", int'(errAtDone), int'(!expLock(trip)));
    chk(exA == expExit(mr1Base) && !odtAtExit, "R9 exit MRS", int'(exA), int'(expExit(mr1Base)));
    chk(doneN == 1, "R10 single done", doneN, 1);
    repeat (3) @(negedge clk);
    chk(lockFlag == expLock(trip) && int'(delayCode) == expCode(trip) && !odt,
        "R11 idle hold", int'(delayCode), expCode(trip));
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({cmdMrs, odt, dqsOe, dqsPulse, lockFlag, errFlag, done} == '0 && delayCode == '0 && mrAddr == '0,
        "R11 reset outputs", int'(delayCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!cmdMrs && !odt && !done, "R11 idle after reset", int'(cmdMrs), 0);
    // directed corners
    runOne(1, 1'b0, 0, 1'b0);
    runOne(TOP, 1'b1, 3, 1'b0);
    runOne(0, 1'b0, 0, 1'b0);       // R8 answers 1 from the start
    runOne(TOP + 1, 1'b1, 6, 1'b0); // R8 never answers
    runOne(7, 1'b1, 7, 1'b1);       // R10 start poked mid-run
    // random runs
    for (int i = 0; i < 10; i++)
      runOne($urandom_range(0, TOP + 1), 1'($urandom), $urandom_range(0, DQ_W - 1), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule